// File: doc/BRIEF.md
# Programmable-Format Serial Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A line-control byte sets the frame format: 5 to 8 data bits, one, one-and-a-half or two stop bits, and an optional parity bit that is odd, even or held at a fixed level. The same byte can also force the line low to send a break. The frame is paced by a 16x baud tick that arrives from outside the block. Each bit lasts sixteen ticks, and a half stop bit lasts eight.

Software or a surrounding controller writes a character into a one-entry holding register. When the shift engine is free, the character moves from the holding register into it on the next clock. The line-control value is captured at that moment, so format changes made during a frame only apply to the next character. The break override is the exception. It acts on the line as soon as it is set and stays in force until it is cleared. Frame timing keeps running underneath a break. When the holding register is loaded again before the current frame ends, the next frame starts right after the last stop period with no idle gap.

Top module: `serial_char_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress and no break is requested, `txd` is 1, `busy` is 0 and `hold_empty` is 1.
- R2: `line_ctl[1:0]` sets how many data bits are sent: 0 sends 5, 1 sends 6, 2 sends 7 and 3 sends 8. Character bits above that length are not sent and do not affect parity.
- R3: A frame starts with one start bit at 0. The data bits follow, least significant bit first. Each start, data and parity bit lasts 16 ticks of `tick16`.
- R4: With `line_ctl[2]` = 0 the stop period is 16 ticks at 1. With `line_ctl[2]` = 1 it is 24 ticks for a 5-bit length and 32 ticks otherwise. `busy` stays 1 through the stop period and drops in the cycle after it ends.
- R5: With `line_ctl[3]` = 1, a parity bit is sent between the last data bit and the stop period. With `line_ctl[4]` = 0 the number of ones in the data bits plus the parity bit is odd. With `line_ctl[4]` = 1 it is even.
- R6: With `line_ctl[3]` and `line_ctl[5]` both 1, the parity bit is the inverse of `line_ctl[4]`.
- R7: While `line_ctl[6]` is 1, `txd` is 0 from the same cycle onward. When it clears, `txd` continues with the frame as if no break had occurred, because bit timing runs on during the break.
- R8: `line_ctl[7]` has no effect on the line or the flags.
- R9: The clock edge that samples `wr_stb` high makes `hold_empty` 0. If the shifter is idle, the character enters it on the following edge, so the start bit appears two edges after the strobe and `hold_empty` returns to 1. A character written during a frame starts straight after that frame's stop period.
- R10: Bit timing advances only on cycles where `tick16` is 1. A frame occupies exactly as many ticks as its bits require, however the ticks are spaced.
- R11: `line_ctl` bits 0 to 5 are sampled when a character enters the shifter. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_stb | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Character to send |
| line_ctl | input | 8 | Line-control byte (length, stop, parity, stick, break, bank bit) |
| txd | output | 1 | Serial output, idles at 1 |
| busy | output | 1 | A frame is being shifted out |
| hold_empty | output | 1 | Holding register can accept a character |

## Verification
The embedded assertions cover the following on every cycle:
- The shifter stalls between ticks.
- The tick counter stays inside the current bit period.
- The data index stays below the selected length.
- The captured format stays frozen during a frame.
- A write always fills the holding register.
- `busy` only rises with a character waiting.
- The bank-select bit never moves the line.

Only the bench scenarios, which compare the whole `txd` and `busy` waveforms against frames built from the requirements, can show the following:
- Bit order.
- Parity values.
- The length of each stop variant.
- Back-to-back chaining.
- The timing kept underneath a break.

// File: rtl/stx_pkg.sv
// Package: shared types for the serial character transmitter.
// Assumes characters are at most 8 bits wide.
package stx_pkg;
    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        STOP_ONE,
        STOP_ONE_HALF,
        STOP_TWO
    } stop_len_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
        stop_len_e  stop_len;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } tx_phase_e;
endpackage

// File: rtl/stx_fmt_decode.sv
// Module: stx_fmt_decode
// Turns the six frame-format bits of the line-control byte into a frame
// configuration. Purely combinational. Assumes the break and bank bits are
// handled elsewhere.
module stx_fmt_decode
    import stx_pkg::*;
(
    input  logic [5:0]  fmt_bits,
    output frame_cfg_t  cfg
);
    // decode length, parity mode and stop length
    always_comb begin
        cfg.nbits     = 4'd5 + {2'b00, fmt_bits[1:0]};
        cfg.par_en    = fmt_bits[3];
        cfg.par_even  = fmt_bits[4];
        cfg.par_stick = fmt_bits[5];
        if (!fmt_bits[2])
            cfg.stop_len = STOP_ONE;
        else if (fmt_bits[1:0] == 2'b00)
            cfg.stop_len = STOP_ONE_HALF;
        else
            cfg.stop_len = STOP_TWO;
    end
endmodule

// File: rtl/stx_hold.sv
// Module: stx_hold
// One-character holding register in front of the shifter. A write always
// wins, and when it coincides with a transfer the shifter takes the old value.
// Assumes `take` is only raised while the register is full.
module stx_hold
    import stx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              take,
    output logic [CHAR_W-1:0] hold_data,
    output logic              hold_full
);
    // capture written characters and track occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (wr_stb) begin
            hold_data <= wr_data;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    assert_write_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (hold_full && hold_data == $past(wr_data)));
endmodule

// File: rtl/stx_shift.sv
// Module: stx_shift
// Frame engine: it loads a character and its format from the holding
// register, then steps through start, data, parity and stop periods, with
// the bit periods counted in baud ticks. Assumes `tick16` is a single-cycle
// pulse.
module stx_shift
    import stx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [CHAR_W-1:0] hold_data,
    input  frame_cfg_t        cfg_in,
    output logic              take,
    output logic              line_bit,
    output logic              busy
);
    localparam int CW    = $clog2(2 * OVERSAMPLE + 1);
    localparam int IDX_W = $clog2(CHAR_W);
    localparam logic [CW-1:0] LIM_BIT  = CW'(OVERSAMPLE);
    localparam logic [CW-1:0] LIM_HALF = CW'(OVERSAMPLE + OVERSAMPLE / 2);
    localparam logic [CW-1:0] LIM_TWO  = CW'(2 * OVERSAMPLE);

    tx_phase_e         state;
    logic [CW-1:0]     cnt;
    logic [IDX_W-1:0]  idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_q;
    frame_cfg_t        cfg_q;

    logic [CW-1:0]     limit;
    logic              phase_end;
    logic              last_bit;
    logic [CHAR_W-1:0] masked;
    logic              par_new;

    // length of the current period in ticks
    always_comb begin
        limit = LIM_BIT;
        if (state == PH_STOP) begin
            case (cfg_q.stop_len)
                STOP_ONE_HALF: limit = LIM_HALF;
                STOP_TWO:      limit = LIM_TWO;
                default:       limit = LIM_BIT;
            endcase
        end
    end

    assign phase_end = tick && (cnt == limit - 1'b1);
    assign last_bit  = ({1'b0, idx} == cfg_q.nbits - 4'd1);
    assign take      = hold_full && ((state == PH_IDLE) || (state == PH_STOP && phase_end));
    assign busy      = (state != PH_IDLE);

    // clear character bits above the selected length
    generate
        for (genvar gi = 0; gi < CHAR_W; gi++) begin : g_mask
            assign masked[gi] = hold_data[gi] && (gi < int'(cfg_in.nbits));
        end
    endgenerate

    // parity value of the character being loaded
    always_comb begin
        if (cfg_in.par_stick)
            par_new = ~cfg_in.par_even;
        else if (cfg_in.par_even)
            par_new = ^masked;
        else
            par_new = ~(^masked);
    end

    // frame sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            par_q <= 1'b0;
            cfg_q <= '0;
        end else if (take) begin
            state <= PH_START;
            cnt   <= '0;
            idx   <= '0;
            shreg <= masked;
            par_q <= par_new;
            cfg_q <= cfg_in;
        end else if (state != PH_IDLE && tick) begin
            if (phase_end) begin
                cnt <= '0;
                case (state)
                    PH_START: begin
                        state <= PH_DATA;
                        idx   <= '0;
                    end
                    PH_DATA: begin
                        shreg <= shreg >> 1;
                        idx   <= idx + 1'b1;
                        if (last_bit)
                            state <= cfg_q.par_en ? PH_PARITY : PH_STOP;
                    end
                    PH_PARITY: state <= PH_STOP;
                    default:   state <= PH_IDLE;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // line level for the current period
    always_comb begin
        case (state)
            PH_START:  line_bit = 1'b0;
            PH_DATA:   line_bit = shreg[0];
            PH_PARITY: line_bit = par_q;
            default:   line_bit = 1'b1;
        endcase
    end

    assert_stall_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE && !tick) |=> ($stable(state) && $stable(cnt)));

    assert_count_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE) |-> (cnt < limit));

    assert_index_in_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_DATA) |-> ({1'b0, idx} < cfg_q.nbits));

    assert_format_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE && !take) |=> $stable(cfg_q));
endmodule

// File: rtl/serial_char_tx.sv
// Module: serial_char_tx
// Top level of the serial character transmitter: format decode, holding
// register and frame engine, with the break override applied at the output.
// Assumes `tick16` comes from an external baud generator.
module serial_char_tx
    import stx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic [7:0] line_ctl,
    output logic       txd,
    output logic       busy,
    output logic       hold_empty
);
    frame_cfg_t        cfg;
    logic              take;
    logic              hold_full;
    logic [CHAR_W-1:0] hold_data;
    logic              line_bit;

    stx_fmt_decode u_dec (
        .fmt_bits (line_ctl[5:0]),
        .cfg      (cfg)
    );

    stx_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    stx_shift #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .cfg_in    (cfg),
        .take      (take),
        .line_bit  (line_bit),
        .busy      (busy)
    );

    // break forces the line low without stopping the engine
    assign txd        = line_bit & ~line_ctl[6];
    assign hold_empty = ~hold_full;

    assert_busy_needs_char_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!hold_empty));

    assert_bank_bit_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && !$stable(line_ctl[7]) && $stable(line_ctl[6]) && !$past(tick16))
        |-> $stable(txd));
endmodule

// File: tb/sim_serial_char_tx.sv
`timescale 1ns/1ps
module sim_serial_char_tx;
    localparam int WIN = 420;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] line_ctl = '0;
    logic       txd, busy, hold_empty;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_div = 1;
    int tick_ph  = 0;
    logic exp_txd [WIN];

    serial_char_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_stb(wr_stb),
        .wr_data(wr_data), .line_ctl(line_ctl), .txd(txd), .busy(busy),
        .hold_empty(hold_empty)
    );

    always #4 clk = ~clk;

    // tick generator, changes away from the active edge
    always @(negedge clk) begin
        if (tick_div <= 1) begin
            tick16 = 1'b1;
        end else begin
            tick_ph = (tick_ph + 1) % tick_div;
            tick16  = (tick_ph == 0);
        end
    end

    task automatic check(input string req, input bit ok, input int act, input int exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // build the expected waveform of one frame, return its length in ticks
    function automatic int put_frame(int at, logic [7:0] d, logic [7:0] c);
        int n, pos, stp;
        logic ones, p;
        n = 5 + int'(c[1:0]);
        pos = at;
        ones = 1'b0;
        for (int k = 0; k < 16; k++) begin
            if (pos < WIN) exp_txd[pos] = 1'b0;
            pos++;
        end
        for (int b = 0; b < n; b++) begin
            ones ^= d[b];
            for (int k = 0; k < 16; k++) begin
                if (pos < WIN) exp_txd[pos] = d[b];
                pos++;
            end
        end
        if (c[3]) begin
            p = c[5] ? ~c[4] : (c[4] ? ones : ~ones);
            for (int k = 0; k < 16; k++) begin
                if (pos < WIN) exp_txd[pos] = p;
                pos++;
            end
        end
        stp = !c[2] ? 16 : (n == 5 ? 24 : 32);
        return pos - at + stp;
    endfunction

    // send a character and compare txd/busy over the whole window
    task automatic run_frame(input string req, input logic [7:0] d, input logic [7:0] c,
                             input int mid_at, input logic [7:0] c_mid,
                             input int brk_on, input int brk_off,
                             input int w2_at, input logic [7:0] d2);
        int len, tot, bad_t, bad_b, first_t, first_b;
        logic got_t, got_b, exp_b;
        logic [7:0] base;
        for (int i = 0; i < WIN; i++) exp_txd[i] = 1'b1;
        len = put_frame(0, d, c);
        tot = len;
        if (w2_at >= 0) tot = len + put_frame(len, d2, c);
        for (int i = brk_on; i < brk_off; i++) exp_txd[i] = 1'b0;
        bad_t = 0; bad_b = 0; first_t = -1; first_b = -1;
        @(negedge clk);
        line_ctl = c;
        wr_data  = d;
        wr_stb   = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            base = (i >= mid_at) ? c_mid : c;
            base[6] = (i >= brk_on && i < brk_off);
            line_ctl = base;
            wr_stb = (i == w2_at);
            if (i == w2_at) wr_data = d2;
            #1;
            got_t = txd;
            got_b = busy;
            exp_b = (i < tot);
            if (got_t !== exp_txd[i]) begin bad_t++; if (first_t < 0) first_t = i; end
            if (got_b !== exp_b) begin bad_b++; if (first_b < 0) first_b = i; end
            if (i == 0 && w2_at < 0)
                check(req, hold_empty === 1'b1, hold_empty, 1, "hold_empty after load");
            if (w2_at >= 0 && i == w2_at + 1)
                check("R9", hold_empty === 1'b0, hold_empty, 0, "hold_empty after write");
            if (w2_at >= 0 && i == len)
                check("R9", hold_empty === 1'b1, hold_empty, 1, "hold_empty after chained load");
        end
        wr_stb = 1'b0;
        line_ctl = 8'h03;
        check(req, bad_t == 0, first_t, -1, "txd waveform first mismatch cycle");
        check(req, bad_b == 0, first_b, -1, "busy waveform first mismatch cycle");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1", txd === 1'b1, txd, 1, "txd after reset");
        check("R1", busy === 1'b0, busy, 0, "busy after reset");
        check("R1", hold_empty === 1'b1, hold_empty, 1, "hold_empty after reset");
    endtask

    task automatic t_lengths();
        run_frame("R3", 8'hA5, 8'h03, WIN, 8'h03, WIN, WIN, -1, 8'h00);
        run_frame("R2", 8'hEA, 8'h00, WIN, 8'h00, WIN, WIN, -1, 8'h00);
        run_frame("R2", 8'hD3, 8'h01, WIN, 8'h01, WIN, WIN, -1, 8'h00);
        run_frame("R2", 8'h96, 8'h02, WIN, 8'h02, WIN, WIN, -1, 8'h00);
    endtask

    task automatic t_stop();
        run_frame("R4", 8'h15, 8'h04, WIN, 8'h04, WIN, WIN, -1, 8'h00);
        run_frame("R4", 8'h3C, 8'h07, WIN, 8'h07, WIN, WIN, -1, 8'h00);
    endtask

    task automatic t_parity();
        run_frame("R5", 8'h03, 8'h0B, WIN, 8'h0B, WIN, WIN, -1, 8'h00);
        run_frame("R5", 8'h07, 8'h1B, WIN, 8'h1B, WIN, WIN, -1, 8'h00);
        run_frame("R5", 8'h80, 8'h0A, WIN, 8'h0A, WIN, WIN, -1, 8'h00);
    endtask

    task automatic t_stick();
        run_frame("R6", 8'h01, 8'h2B, WIN, 8'h2B, WIN, WIN, -1, 8'h00);
        run_frame("R6", 8'h01, 8'h3B, WIN, 8'h3B, WIN, WIN, -1, 8'h00);
    endtask

    task automatic t_break();
        run_frame("R7", 8'h5A, 8'h03, WIN, 8'h03, 30, 70, -1, 8'h00);
    endtask

    task automatic t_bank_bit();
        run_frame("R8", 8'h69, 8'h83, 40, 8'h03, WIN, WIN, -1, 8'h00);
    endtask

    task automatic t_chain();
        run_frame("R9", 8'h4D, 8'h03, WIN, 8'h03, WIN, WIN, 20, 8'hB2);
    endtask

    task automatic t_format_sampled();
        run_frame("R11", 8'hC3, 8'h03, 50, 8'h1F, WIN, WIN, -1, 8'h00);
    endtask

    task automatic t_pacing();
        int ticks, cycles;
        bit seen;
        tick_div = 3;
        @(negedge clk);
        line_ctl = 8'h03;
        wr_data  = 8'h00;
        wr_stb   = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        ticks = 0; cycles = 0; seen = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            #1;
            if (busy) begin
                seen = 1;
                cycles++;
                if (tick16) ticks++;
            end else if (seen) begin
                break;
            end
        end
        check("R10", ticks == 160, ticks, 160, "ticks consumed by 8N1 frame");
        check("R10", cycles >= 477, cycles, 477, "frame cycles at one tick per three clocks");
        tick_div = 1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        summary();
        $finish;
    end

    initial begin
        line_ctl = 8'h03;
        t_reset();
        t_lengths();
        t_stop();
        t_parity();
        t_stick();
        t_break();
        t_bank_bit();
        t_chain();
        t_format_sampled();
        t_pacing();
        #1;
        check("R1", txd === 1'b1 && busy === 1'b0, txd, 1, "idle line after all frames");
        summary();
        $finish;
    end
endmodule